// File: doc/BRIEF.md
# Write-Strobe Qualification Guard

This block stands between the raw active-low chip-select, write-enable and output-enable strobes of a nonvolatile memory and the engine that performs its writes. It emits one active-high write strobe, and only for strobe activity that is safe to act on. A logic-level supply-good flag arrives from an external comparator. While that flag is low, no write passes. After the flag rises, writes stay locked out for a fixed hold-off time counted in clock cycles.

Any strobe activity that overlaps a low output-enable is treated as a read-side access and blocked. A low phase is defined as chip-select and write-enable both low at the same time. A low phase shorter than a programmable number of clock cycles is treated as noise. If a low phase starts while writes are forbidden, it stays void until both strobes are no longer low together. This holds even when the inhibit condition clears partway through. The qualified strobe is released as soon as either raw strobe returns high.

All inputs are sampled on the rising clock edge. The output is a register, so it changes only on a clock edge.

Top module: `wr_inhibit_guard`

## Requirements
- R1: While the active-low reset is asserted, `wr_strobe_o` is 0.
- R2: `wr_strobe_o` is 1 only if `supply_ok_i` was 1 at the preceding clock edge. With `supply_ok_i` held at 0, no strobe pattern ever produces a 1.
- R3: After `supply_ok_i` rises, writes stay locked out until it has been sampled 1 at `PWR_DELAY` consecutive edges. A low phase first sampled at one of those edges never qualifies. A low phase first sampled at edge `PWR_DELAY+1` can qualify.
- R4: `wr_strobe_o` is 1 only if `oe_n_i` was 1 at the preceding edge. A low `oe_n_i` blocks the write regardless of the other strobes.
- R5: A low phase means `cs_n_i`=0 and `we_n_i`=0 together. `wr_strobe_o` rises right after the `MIN_WIDTH`-th consecutive edge at which a qualifying low phase is sampled. A low phase lasting fewer edges never produces a 1.
- R6: At any edge where `cs_n_i` or `we_n_i` is sampled 1, `wr_strobe_o` becomes 0 after that edge. This applies whether chip-select or write-enable ends the phase.
- R7: If `supply_ok_i` is sampled 0 while a write is qualified, `wr_strobe_o` drops after that edge. The full `PWR_DELAY` lockout then starts again from zero.
- R8: A low phase during which `oe_n_i`=0 or the lockout is seen at any edge stays void until the low phase ends. This holds even if the inhibit condition clears while both strobes are still low.
- R9: While a qualified low phase continues with `oe_n_i`=1 and `supply_ok_i`=1, `wr_strobe_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good flag from an external comparator, 1 = supply in range |
| cs_n_i | input | 1 | Raw chip-select, active low |
| we_n_i | input | 1 | Raw write-enable, active low |
| oe_n_i | input | 1 | Raw output-enable, active low |
| wr_strobe_o | output | 1 | Qualified write strobe, active high |

## Verification
The bound checker enforces, on every cycle, the invariants that can be read from a single strobe edge:
- a high output implies a good supply and a high output-enable at the previous edge;
- the output never rises before the minimum count of low-phase samples;
- the output never rises before the hold-off count of supply-good samples;
- the output drops whenever a raw strobe is sampled high;
- the output holds while a qualified phase continues.

Other behaviours depend on a whole stimulus history, and only the bench scenarios can show them:
- a phase voided by output-enable or by the hold-off stays void after that condition clears;
- an abort on a supply drop restarts the full delay;
- the exact boundary edge at which a late-starting phase first becomes eligible.

// File: rtl/wig_pkg.sv
package wig_pkg;

    // Raw strobes as seen on the memory pins, all active low.
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
    } wig_strobe_t;

    // A write low phase: chip-select and write-enable low together.
    function automatic logic wig_low_phase(wig_strobe_t s);
        return (!s.cs_n) && (!s.we_n);
    endfunction

    // Read side active: output-enable low forbids any write.
    function automatic logic wig_read_side(wig_strobe_t s);
        return !s.oe_n;
    endfunction

endpackage

// File: rtl/wig_holdoff.sv
module wig_holdoff #(
    parameter int unsigned PWR_DELAY = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic supply_ok_i,
    output logic ready_o
);

    generate
        if (PWR_DELAY == 0) begin : g_no_delay
            // No hold-off: writes are allowed whenever the supply is good.
            assign ready_o = supply_ok_i;
        end else begin : g_delay
            localparam int unsigned CW = $clog2(PWR_DELAY + 1);
            localparam logic [CW-1:0] CNT_MAX = CW'(PWR_DELAY);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } hold_st_t;

            hold_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (!supply_ok_i) begin
                    // Any supply drop restarts the whole lockout.
                    st_d.cnt = '0;
                end else if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            // Using the live supply flag makes a drop take effect on the same edge.
            assign ready_o = supply_ok_i && (st_q.cnt == CNT_MAX);
        end
    endgenerate

endmodule

// File: rtl/wig_pulse_qual.sv
module wig_pulse_qual
    import wig_pkg::*;
#(
    parameter int unsigned MIN_WIDTH = 3
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  wig_strobe_t strb_i,
    input  logic        ready_i,
    output logic        strobe_o
);

    localparam int unsigned WIDTH_EFF = (MIN_WIDTH == 0) ? 1 : MIN_WIDTH;
    localparam int unsigned WW        = $clog2(WIDTH_EFF + 1);
    localparam logic [WW-1:0] RUN_MAX = WW'(WIDTH_EFF);

    typedef struct packed {
        logic          spoiled;
        logic [WW-1:0] run;
        logic          strobe;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     low_phase;
    logic     inhibit;

    always_comb begin
        low_phase = wig_low_phase(strb_i);
        inhibit   = wig_read_side(strb_i) || !ready_i;
        st_d      = st_q;

        // Once a low phase has seen any inhibit, it stays void until it ends.
        st_d.spoiled = low_phase && (st_q.spoiled || inhibit);

        if (low_phase && !st_d.spoiled) begin
            if (st_q.run != RUN_MAX) begin
                st_d.run = st_q.run + WW'(1);
            end
        end else begin
            st_d.run = '0;
        end

        st_d.strobe = (st_d.run == RUN_MAX);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;

endmodule

// File: rtl/wr_inhibit_guard.sv
module wr_inhibit_guard
    import wig_pkg::*;
#(
    parameter int unsigned PWR_DELAY = 1000,
    parameter int unsigned MIN_WIDTH = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic supply_ok_i,
    input  logic cs_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    output logic wr_strobe_o
);

    wig_strobe_t strb;
    logic        ready;

    always_comb begin
        strb.cs_n = cs_n_i;
        strb.we_n = we_n_i;
        strb.oe_n = oe_n_i;
    end

    wig_holdoff #(
        .PWR_DELAY (PWR_DELAY)
    ) holdoff_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .supply_ok_i (supply_ok_i),
        .ready_o     (ready)
    );

    wig_pulse_qual #(
        .MIN_WIDTH (MIN_WIDTH)
    ) qual_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strb_i   (strb),
        .ready_i  (ready),
        .strobe_o (wr_strobe_o)
    );

endmodule

// File: rtl/wr_inhibit_guard_chk.sv
module wr_inhibit_guard_chk #(
    parameter int unsigned PWR_DELAY = 1000,
    parameter int unsigned MIN_WIDTH = 3
) (
    input logic clk_i,
    input logic rst_ni,
    input logic supply_ok_i,
    input logic cs_n_i,
    input logic we_n_i,
    input logic oe_n_i,
    input logic wr_strobe_o
);

    localparam int unsigned WIDTH_EFF = (MIN_WIDTH == 0) ? 1 : MIN_WIDTH;
    localparam int unsigned LW        = $clog2(WIDTH_EFF + 1);
    localparam int unsigned UW        = $clog2(PWR_DELAY + 2);
    localparam logic [LW-1:0] LOW_SAT = LW'(WIDTH_EFF);
    localparam logic [UW-1:0] UP_SAT  = UW'(PWR_DELAY + 1);

    // Independent counts of consecutive low-phase samples and supply-good samples.
    logic [LW-1:0] low_run_q;
    logic [UW-1:0] up_run_q;
    logic          low_now;

    assign low_now = !cs_n_i && !we_n_i && oe_n_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_run_q <= '0;
            up_run_q  <= '0;
        end else begin
            if (!low_now) begin
                low_run_q <= '0;
            end else if (low_run_q != LOW_SAT) begin
                low_run_q <= low_run_q + LW'(1);
            end
            if (!supply_ok_i) begin
                up_run_q <= '0;
            end else if (up_run_q != UP_SAT) begin
                up_run_q <= up_run_q + UW'(1);
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |-> !wr_strobe_o);

    a_r2_supply_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_strobe_o |-> $past(supply_ok_i));

    a_r3_holdoff_elapsed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_strobe_o |-> (up_run_q == UP_SAT));

    a_r4_oe_interlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_strobe_o |-> $past(oe_n_i));

    a_r5_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_strobe_o) |-> (low_run_q == LOW_SAT));

    a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_n_i || we_n_i) |=> !wr_strobe_o);

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_strobe_o && low_now && supply_ok_i) |=> wr_strobe_o);

endmodule

bind wr_inhibit_guard wr_inhibit_guard_chk #(
    .PWR_DELAY (PWR_DELAY),
    .MIN_WIDTH (MIN_WIDTH)
) chk_i (.*);

// File: tb/wr_inhibit_guard_tb_top.sv
module wr_inhibit_guard_tb_top;

    localparam int unsigned D = 12;
    localparam int unsigned W = 3;

    // Vector bits: [4] supply_ok, [3] cs_n, [2] we_n, [1] oe_n, [0] expected strobe.
    localparam int NVEC = 28;
    localparam logic [4:0] VEC [NVEC] = '{
        5'b11110, 5'b10010, 5'b10010, 5'b10011, 5'b10011, // R5 fire, R9 hold
        5'b11010, 5'b11110,                               // R6 release by cs
        5'b10010, 5'b10010, 5'b10110,                     // R5 short pulse
        5'b10010, 5'b10010, 5'b10011, 5'b10000,           // R4 oe low drops it
        5'b10010, 5'b10010, 5'b11110,                     // R8 stays void
        5'b10000, 5'b10000, 5'b10000, 5'b10000, 5'b11110, // R4 oe low throughout
        5'b10110, 5'b10010, 5'b10010, 5'b10011,           // R5 we-controlled
        5'b10110, 5'b11110                                // R6 release by we
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup = 1'b0;
    logic cs_n = 1'b1;
    logic we_n = 1'b1;
    logic oe_n = 1'b1;
    logic strobe;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wr_inhibit_guard #(
        .PWR_DELAY (D),
        .MIN_WIDTH (W)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .supply_ok_i (sup),
        .cs_n_i      (cs_n),
        .we_n_i      (we_n),
        .oe_n_i      (oe_n),
        .wr_strobe_o (strobe)
    );

    task automatic step(input logic s, input logic c, input logic w, input logic o);
        @(negedge clk);
        sup  = s;
        cs_n = c;
        we_n = w;
        oe_n = o;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (strobe !== exp) begin
            fails++;
            $display("FAIL %s: wr_strobe_o=%b expected=%b at %0t", req, strobe, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset holds the strobe low even with a full write pattern applied.
        step(1'b1, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R1", 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R1", 1'b0);
        @(negedge clk);
        sup = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b1;

        // Power up and let the hold-off expire before the table.
        for (int i = 0; i < int'(D) + 1; i++) step(1'b1, 1'b1, 1'b1, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            check($sformatf("R4/R5/R6/R8/R9 vec%0d", i), VEC[i][0]);
        end

        // R2: supply low blocks a long pulse.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < int'(W) + 3; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1);
            check("R2", 1'b0);
        end
        step(1'b0, 1'b1, 1'b1, 1'b1);

        // R3/R8: a phase first sampled at edge D after supply rise is void.
        for (int i = 0; i < int'(D) - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < int'(W) + 2; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b1);
            check("R3 early phase", 1'b0);
        end
        step(1'b1, 1'b1, 1'b1, 1'b1);

        // R3/R5: a phase first sampled at edge D+1 qualifies after W edges.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < int'(D); i++) step(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < int'(W) - 1; i++) step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R5 before width", 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R3 boundary phase", 1'b1);

        // R7: supply drop aborts at once and the phase stays void afterwards.
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 abort", 1'b0);
        for (int i = 0; i < int'(W) + 1; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b1);
            check("R7 after abort", 1'b0);
        end
        step(1'b1, 1'b1, 1'b1, 1'b1);

        // R7: lockout restarted from zero, so edge D after return is still locked.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < int'(D) - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < int'(W) + 1; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b1);
            check("R7 restarted delay", 1'b0);
        end
        step(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < int'(W); i++) step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R7 ready again", 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check("R6", 1'b0);

        finish_run();
    end

endmodule